// File: doc/BRIEF.md
# Pulse Interval Recorder

This block measures, in clock cycles, how far apart the rising edges of a synchronous pulse input are. It does not clear a counter at every edge. A single timestamp counter starts running at the first rising edge. At each later edge the block samples that counter and subtracts the value it sampled at the previous edge. The difference is the interval.

Intervals are written in arrival order into a small indexed table through a write pointer. A second stage adds each stored interval to the one stored after it, which gives pair sums. A read index selects one table slot. The block returns the interval in that slot, the pair sum that starts at that slot with its validity, and the number of slots filled so far.

Top module: `pulse_interval_recorder`

## Requirements
- R1: Until the first rising edge of `pulse_in` after reset, the timestamp counter stays at zero. The first edge starts it but records no interval, so `valid_count` stays 0.
- R2: An edge is a cycle where `pulse_in` is 1 and was 0 in the previous cycle. A pulse held high for several cycles counts as one edge, so two edges are always at least 2 cycles apart.
- R3: The first stored interval (slot 0) is the raw timestamp taken at the second edge. This equals the number of clock cycles from the first edge to the second.
- R4: Every later stored interval is the timestamp at its edge minus the timestamp at the edge before it. This equals the cycle distance between the two edges; for example, edges 5, 3, 4, 2 and 6 cycles apart store 5, 3, 4, 2, 6.
- R5: Intervals fill slots 0, 1, 2, … in order. An interval can be read at `interval_out` through `rd_idx` from the cycle after the clock edge that detects its closing pulse edge.
- R6: The subtraction is taken modulo 2^16. An interval below 65536 cycles is stored correctly even when the timestamp counter wraps between its two edges.
- R7: The table has 16 slots of 16 bits. After slot 15 the write pointer returns to slot 0 and overwrites it. `valid_count` rises by one per stored interval and stops at 16.
- R8: `pair_sum_out` is the 17-bit sum of slot `rd_idx` and slot `rd_idx`+1. `pair_valid` is 1 only when both slots hold stored intervals (`rd_idx`+1 < `valid_count`). When `pair_valid` is 0, `pair_sum_out` is 0.
- R9: A synchronous active-high `rst` clears the timestamp, the last sampled timestamp, the write pointer, the count and every slot. The block then waits again for a first edge, and every slot reads 0.
- R10: Slot 15 has no successor, so at `rd_idx` = 15 `pair_valid` is 0 and `pair_sum_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Pulse input, already synchronous to clk |
| rd_idx | input | 4 | Slot to read |
| interval_out | output | 16 | Interval stored in slot rd_idx |
| pair_sum_out | output | 17 | Slot rd_idx plus slot rd_idx+1, or 0 when not valid |
| pair_valid | output | 1 | Both slots of the pair hold stored intervals |
| valid_count | output | 5 | Number of stored intervals, saturating at 16 |

## Verification
An interval is written at the clock edge that samples the rise of its closing pulse. From then on it is readable combinationally through `rd_idx`, and `valid_count` changes at that same edge. The bench raises `pulse_in` on a falling clock edge and counts every falling edge until the next rise, so the expected interval is the number of clock edges between rises. The bench sweeps the whole table only after the last pulse of a sequence has settled, so time spent reading never shifts an interval still being measured. Sequences cover held-high pulses, more than 16 intervals, and a timestamp wrap.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int PIR_TS_W  = 16;
  localparam int PIR_DEPTH = 16;

  typedef enum logic {
    PH_WAIT_FIRST = 1'b0,
    PH_MEASURING  = 1'b1
  } pir_phase_e;
endpackage

// File: rtl/pir_edge_timer.sv
module pir_edge_timer
  import pir_pkg::*;
#(
  parameter int TSW = PIR_TS_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pulse_in,
  output logic           edge_o,
  output logic           started_o,
  output logic [TSW-1:0] ts_o,
  output logic           cap_o,
  output logic [TSW-1:0] intv_o
);
  // interval between two samples of a wrapping counter
  function automatic logic [TSW-1:0] ts_delta(input logic [TSW-1:0] now_ts,
                                              input logic [TSW-1:0] prev_ts);
    return now_ts - prev_ts;
  endfunction

  logic       pulse_q;
  pir_phase_e phase;
  logic [TSW-1:0] ts, last_ts;

  assign edge_o    = pulse_in & ~pulse_q;
  assign started_o = (phase == PH_MEASURING);
  assign ts_o      = ts;
  assign cap_o     = edge_o & started_o;
  assign intv_o    = ts_delta(ts, last_ts);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      phase   <= PH_WAIT_FIRST;
      ts      <= '0;
      last_ts <= '0;
    end else begin
      pulse_q <= pulse_in;
      if (started_o || edge_o) ts <= ts + 1'b1;
      if (edge_o) phase <= PH_MEASURING;
      if (cap_o) last_ts <= ts;
    end
  end
endmodule

// File: rtl/pir_store.sv
module pir_store
  import pir_pkg::*;
#(
  parameter int DEPTH = PIR_DEPTH,
  parameter int W     = PIR_TS_W,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [W-1:0]              wr_data,
  input  logic [IW-1:0]             rd_idx,
  output logic [W-1:0]              rd_data,
  output logic [DEPTH-1:0][W-1:0]   slots_o,
  output logic [CW-1:0]             count_o,
  output logic [IW-1:0]             wptr_o
);
  logic [IW-1:0] wptr;
  logic [CW-1:0] count;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slots_o[i] <= '0;
      else if (wr_en && (wptr == IW'(i))) slots_o[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      count <= '0;
    end else if (wr_en) begin
      wptr <= (wptr == IW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (count != CW'(DEPTH)) count <= count + 1'b1;
    end
  end

  assign rd_data = (int'(rd_idx) < DEPTH) ? slots_o[rd_idx] : '0;
  assign count_o = count;
  assign wptr_o  = wptr;
endmodule

// File: rtl/pir_pairs.sv
module pir_pairs
  import pir_pkg::*;
#(
  parameter int DEPTH = PIR_DEPTH,
  parameter int W     = PIR_TS_W,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][W-1:0] slots,
  input  logic [CW-1:0]           count,
  input  logic [IW-1:0]           rd_idx,
  output logic [W:0]              sum_o,
  output logic                    valid_o
);
  function automatic logic [W:0] pair_add(input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [DEPTH-1:0][W:0] sums;
  logic [DEPTH-1:0]      oks;

  for (genvar i = 0; i < DEPTH; i++) begin : g_pair
    if (i < DEPTH - 1) begin : g_has_next
      assign oks[i]  = (count >= CW'(i + 2));
      assign sums[i] = oks[i] ? pair_add(slots[i], slots[i+1]) : '0;
    end else begin : g_last
      assign oks[i]  = 1'b0;
      assign sums[i] = '0;
    end
  end

  always_comb begin
    if (int'(rd_idx) < DEPTH) begin
      sum_o   = sums[rd_idx];
      valid_o = oks[rd_idx];
    end else begin
      sum_o   = '0;
      valid_o = 1'b0;
    end
  end
endmodule

// File: rtl/pulse_interval_recorder.sv
module pulse_interval_recorder
  import pir_pkg::*;
#(
  parameter int TSW   = PIR_TS_W,
  parameter int DEPTH = PIR_DEPTH,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pulse_in,
  input  logic [IW-1:0] rd_idx,
  output logic [TSW-1:0] interval_out,
  output logic [TSW:0]   pair_sum_out,
  output logic           pair_valid,
  output logic [CW-1:0]  valid_count
);
  // named internal events for the checker
  logic                       edge_det;
  logic                       started;
  logic [TSW-1:0]             ts_now;
  logic                       wr_en;
  logic [TSW-1:0]             new_intv;
  logic [DEPTH-1:0][TSW-1:0]  slots;
  logic [IW-1:0]              wr_ptr;

  pir_edge_timer #(.TSW(TSW)) u_timer (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .edge_o(edge_det), .started_o(started), .ts_o(ts_now),
    .cap_o(wr_en), .intv_o(new_intv)
  );

  pir_store #(.DEPTH(DEPTH), .W(TSW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(new_intv),
    .rd_idx(rd_idx), .rd_data(interval_out), .slots_o(slots),
    .count_o(valid_count), .wptr_o(wr_ptr)
  );

  pir_pairs #(.DEPTH(DEPTH), .W(TSW)) u_pairs (
    .slots(slots), .count(valid_count), .rd_idx(rd_idx),
    .sum_o(pair_sum_out), .valid_o(pair_valid)
  );
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
  parameter int TSW   = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           edge_det,
  input logic           started,
  input logic [TSW-1:0] ts_now,
  input logic           wr_en,
  input logic [CW-1:0]  valid_count,
  input logic [IW-1:0]  rd_idx,
  input logic           pair_valid,
  input logic [TSW:0]   pair_sum_out
);
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !started |-> ts_now == '0);

  a_r1_first_edge_no_store: assert property (@(posedge clk) disable iff (rst)
    (edge_det && !started) |=> valid_count == $past(valid_count));

  a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
    edge_det |=> !edge_det);

  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(valid_count) < DEPTH) |=> valid_count == $past(valid_count) + 1'b1);

  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    int'(valid_count) <= DEPTH);

  a_r8_pair_needs_two: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> int'(rd_idx) + 2 <= int'(valid_count));

  a_r10_last_no_pair: assert property (@(posedge clk) disable iff (rst)
    int'(rd_idx) == DEPTH - 1 |-> (!pair_valid && pair_sum_out == '0));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (valid_count == '0 && !started && ts_now == '0));
endmodule

bind pulse_interval_recorder pir_checker #(.TSW(TSW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .edge_det(edge_det), .started(started),
  .ts_now(ts_now), .wr_en(wr_en), .valid_count(valid_count),
  .rd_idx(rd_idx), .pair_valid(pair_valid), .pair_sum_out(pair_sum_out)
);

// File: tb/pulse_interval_recorder_test.sv
module pulse_interval_recorder_test;
  localparam int DEPTH = 16;
  localparam int TSW   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pulse_in = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic [15:0] interval_out;
  logic [16:0] pair_sum_out;
  logic        pair_valid;
  logic [4:0]  valid_count;

  always #4 clk = ~clk;

  pulse_interval_recorder uut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .rd_idx(rd_idx),
    .interval_out(interval_out), .pair_sum_out(pair_sum_out),
    .pair_valid(pair_valid), .valid_count(valid_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int exp_arr [DEPTH];
  int exp_cnt, exp_ptr, prev_gap;
  bit m_started;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) exp_arr[i] = 0;
    exp_cnt = 0; exp_ptr = 0; prev_gap = 0; m_started = 0;
  endtask

  task automatic push(input int v);
    exp_arr[exp_ptr] = v % 65536;
    exp_ptr = (exp_ptr + 1) % DEPTH;
    if (exp_cnt < DEPTH) exp_cnt++;
  endtask

  // raise pulse, hold 'high' cycles; next rise comes 'gap' cycles after this one
  task automatic fire(input int gap, input int high);
    @(negedge clk);
    pulse_in = 1'b1;
    if (m_started) push(prev_gap);
    m_started = 1;
    prev_gap = gap;
    repeat (high) @(negedge clk);
    pulse_in = 1'b0;
    repeat (gap - high - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic sweep(input string tag);
    check({tag, " R7 valid_count"}, valid_count, exp_cnt);
    for (int i = 0; i < DEPTH; i++) begin
      int pv, ps;
      rd_idx = 4'(i);
      #1;
      pv = (i < DEPTH - 1 && i + 1 < exp_cnt) ? 1 : 0;
      ps = pv ? exp_arr[i] + exp_arr[i+1] : 0;
      check($sformatf("%s R5 slot %0d interval", tag, i), interval_out, exp_arr[i]);
      check($sformatf("%s R8/R10 slot %0d pair_valid", tag, i), pair_valid, pv);
      check($sformatf("%s R8/R10 slot %0d pair_sum", tag, i), pair_sum_out, ps);
    end
    rd_idx = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 reset valid_count", valid_count, 0);
    check("R9 reset pair_valid", pair_valid, 0);
    check("R9 reset interval", interval_out, 0);

    // R1 idle and first edge record nothing
    repeat (20) @(negedge clk);
    check("R1 idle valid_count", valid_count, 0);
    fire(5, 1);
    check("R1 first edge stores nothing", valid_count, 0);

    // Sequence A: R2 held-high pulses, R3, R4
    fire(3, 2);
    fire(4, 1);
    fire(2, 1);
    fire(6, 3);
    fire(3, 1);
    check("R2 held-high pulses counted once", valid_count, 5);
    rd_idx = 4'd0; #1;
    check("R3 first interval raw timestamp", interval_out, 5);
    rd_idx = 4'd3; #1;
    check("R4 interval after held pulse", interval_out, 2);
    sweep("seqA");

    // R9 reset clears all slots
    do_reset();
    sweep("after reset R9");

    // Sequence B: more than DEPTH intervals, R7 wrap and saturation
    fire(4, 1);
    for (int k = 0; k < 20; k++) fire((k % 7) + 2, 1);
    fire(3, 1);
    check("R7 saturated count", valid_count, 16);
    sweep("seqB");

    // Sequence C: R6 timestamp wrap between edges
    do_reset();
    fire(30000, 1);
    fire(40000, 1);
    fire(2, 1);
    rd_idx = 4'd1; #1;
    check("R6 interval across timestamp wrap", interval_out, 40000);
    check("R8 17-bit pair sum", pair_sum_out, 0);
    rd_idx = 4'd0; #1;
    check("R8 17-bit pair sum", pair_sum_out, 70000);
    sweep("seqC");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule